// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits on the bus side of a small processor core, between the execution unit and a single memory port. It reads ahead from an instruction pointer and fills a short byte queue. It then hands instruction bytes one at a time to the execution side through a valid/ready handshake. Fetching goes on while the execution side is busy with earlier bytes. A fetch is issued only when the queue can absorb a full word.

The execution side can also ask for one 16-bit operand read or write. That request gets the bus at the next idle cycle, ahead of any prefetch. A redirect command supplies a new fetch address. It empties the queue at once and discards the data of any fetch that is still outstanding. Fetching then resumes at the target address. The memory port uses a request/ready handshake with a 20-bit address and 16-bit little-endian data, and it may stall for any number of cycles.

Top module: `pfq_unit`

## Requirements
- R1: The queue holds at most QDEPTH bytes (default 6) and returns them in arrival order. `q_valid` is high exactly when at least one byte is queued.
- R2: A prefetch is issued only from an idle bus, and only when at least two queue entries are free. With no consumer, an even start fills the queue to 6 bytes and an odd start fills it to 5 bytes, and then the bus goes quiet.
- R3: Each prefetch reads the word at the instruction pointer. From an even address it queues `mem_rdata[7:0]` and then `mem_rdata[15:8]`, and the pointer advances by 2. From an odd address it queues only `mem_rdata[15:8]`, and the pointer advances by 1. The pointer wraps modulo 2^20.
- R4: A byte leaves the queue on a clock edge where `q_valid` and `q_ready` are both high. A byte that is offered and not taken stays at the head.
- R5: A pending data request (`dreq_valid` high, `dreq_done` low) wins the next idle bus cycle over a prefetch. A transaction already in progress is finished first and is never aborted.
- R6: On a data access the port drives `dreq_addr`, with `mem_we` equal to `dreq_write` and `mem_wdata` equal to `dreq_wdata`. `dreq_done` pulses for one cycle, in the cycle after the edge that completes the transfer. For a read, `dreq_rdata` then holds the returned word.
- R7: A redirect empties the queue, so `q_valid` is low in the next cycle. The next prefetch is then issued at `redir_addr`.
- R8: The data of a prefetch that was outstanding when a redirect arrived, including one that completes in the redirect cycle, never enters the queue.
- R9: Once `mem_req` is raised, it stays high with a stable address and write flag until the edge where `mem_ready` is sampled high.
- R10: Synchronous reset empties the queue and clears `mem_req` and `dreq_done`. The first prefetch after reset reads RESET_ADDR (default 0xFFFF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Redirect command, one cycle |
| redir_addr | input | 20 | New fetch address |
| q_valid | output | 1 | Head byte is valid |
| q_byte | output | 8 | Head instruction byte |
| q_ready | input | 1 | Execution side takes the head byte |
| dreq_valid | input | 1 | Data access request, held until done |
| dreq_write | input | 1 | 1 for write, 0 for read |
| dreq_addr | input | 20 | Data access address |
| dreq_wdata | input | 16 | Write data |
| dreq_done | output | 1 | One-cycle completion pulse |
| dreq_rdata | output | 16 | Read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory completes the transfer |
| mem_rdata | input | 16 | Memory read data |

## Verification
The assertions rely on two assumptions about the environment. First, the execution side keeps `dreq_valid` and its address steady until it sees `dreq_done`, and it drops the request in that same cycle. Second, the memory raises `mem_ready` only while a request is open, for a single cycle. The bench's memory model answers after a set number of wait cycles and then returns `mem_ready` low. The requester task releases its request as soon as it sees the done pulse. Redirects last one cycle, and each scenario waits for an idle bus before issuing one, except the case that deliberately hits an outstanding fetch.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_DATA  = 2'd2
  } bus_st_t;

  // bytes delivered by one prefetch, given the low address bit
  function automatic logic [1:0] fetch_len(input logic odd);
    return odd ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [1:0]    push_n,
  input  logic [7:0]    push_d0,
  input  logic [7:0]    push_d1,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] count,
  output logic          nonempty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    store [DEPTH];
  logic [PW-1:0] rptr, wptr, wptr1;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wptr1 = inc(wptr);

  // storage without reset
  always_ff @(posedge clk) begin
    if (push_n != 2'd0) store[wptr] <= push_d0;
    if (push_n == 2'd2) store[wptr1] <= push_d1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      if (pop) rptr <= inc(rptr);
      case (push_n)
        2'd1:    wptr <= wptr1;
        2'd2:    wptr <= inc(wptr1);
        default: wptr <= wptr;
      endcase
      count <= count + CW'(push_n) - CW'(pop);
    end
  end

  assign head     = store[rptr];
  assign nonempty = (count != '0);
endmodule

// File: rtl/pfq_bus_seq.sv
module pfq_bus_seq
  import pfq_pkg::*;
#(
  parameter int           AW         = 20,
  parameter int           DEPTH      = 6,
  parameter int           CW         = $clog2(DEPTH + 1),
  parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_valid,
  input  logic [AW-1:0]     redir_addr,
  input  logic [CW-1:0]     count,
  input  logic              dreq_valid,
  input  logic              dreq_write,
  input  logic [AW-1:0]     dreq_addr,
  input  logic [DATA_W-1:0] dreq_wdata,
  output logic              dreq_done,
  output logic [DATA_W-1:0] dreq_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              flush,
  output logic [1:0]        push_n,
  output logic [7:0]        push_d0,
  output logic [7:0]        push_d1,
  output bus_st_t           st
);
  localparam int FREE_MIN = 2;
  localparam int ROOM_MAX = DEPTH - FREE_MIN;

  logic [AW-1:0] ip;
  logic          stale;
  logic          xfer_end, room, take_data, fetch_keep;

  assign xfer_end   = mem_req & mem_ready;
  assign room       = (count <= CW'(ROOM_MAX));
  assign take_data  = dreq_valid & ~dreq_done;
  assign flush      = redir_valid;
  assign fetch_keep = (st == BUS_FETCH) & xfer_end & ~stale & ~redir_valid;

  always_comb begin
    push_n  = fetch_keep ? fetch_len(mem_addr[0]) : 2'd0;
    push_d0 = mem_addr[0] ? mem_rdata[15:8] : mem_rdata[7:0];
    push_d1 = mem_rdata[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= BUS_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      ip         <= RESET_ADDR;
      stale      <= 1'b0;
      dreq_done  <= 1'b0;
      dreq_rdata <= '0;
    end else begin
      dreq_done <= 1'b0;
      if (redir_valid) ip <= redir_addr;
      case (st)
        BUS_IDLE: begin
          if (take_data) begin
            mem_req   <= 1'b1;
            mem_we    <= dreq_write;
            mem_addr  <= dreq_addr;
            mem_wdata <= dreq_wdata;
            st        <= BUS_DATA;
          end else if (room && !redir_valid) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ip;
            stale    <= 1'b0;
            st       <= BUS_FETCH;
          end
        end
        BUS_FETCH: begin
          if (redir_valid) stale <= 1'b1;
          if (xfer_end) begin
            mem_req <= 1'b0;
            st      <= BUS_IDLE;
            if (!stale && !redir_valid)
              ip <= ip + AW'(fetch_len(mem_addr[0]));
          end
        end
        BUS_DATA: begin
          if (xfer_end) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            st        <= BUS_IDLE;
            dreq_done <= 1'b1;
            if (!mem_we) dreq_rdata <= mem_rdata;
          end
        end
        default: st <= BUS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfq_unit.sv
module pfq_unit
  import pfq_pkg::*;
#(
  parameter int            AW         = 20,
  parameter int            QDEPTH     = 6,
  parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_valid,
  input  logic [AW-1:0]     redir_addr,
  output logic              q_valid,
  output logic [7:0]        q_byte,
  input  logic              q_ready,
  input  logic              dreq_valid,
  input  logic              dreq_write,
  input  logic [AW-1:0]     dreq_addr,
  input  logic [DATA_W-1:0] dreq_wdata,
  output logic              dreq_done,
  output logic [DATA_W-1:0] dreq_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int CW = $clog2(QDEPTH + 1);

  logic [CW-1:0] occ_count;
  logic          q_flush, q_pop;
  logic [1:0]    q_push_n;
  logic [7:0]    q_d0, q_d1;
  bus_st_t       bus_st;

  assign q_pop = q_valid & q_ready & ~q_flush;

  pfq_byte_fifo #(.DEPTH(QDEPTH), .CW(CW)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .flush    (q_flush),
    .push_n   (q_push_n),
    .push_d0  (q_d0),
    .push_d1  (q_d1),
    .pop      (q_pop),
    .head     (q_byte),
    .count    (occ_count),
    .nonempty (q_valid)
  );

  pfq_bus_seq #(.AW(AW), .DEPTH(QDEPTH), .CW(CW), .RESET_ADDR(RESET_ADDR)) u_bus (
    .clk         (clk),
    .rst         (rst),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .count       (occ_count),
    .dreq_valid  (dreq_valid),
    .dreq_write  (dreq_write),
    .dreq_addr   (dreq_addr),
    .dreq_wdata  (dreq_wdata),
    .dreq_done   (dreq_done),
    .dreq_rdata  (dreq_rdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .mem_rdata   (mem_rdata),
    .flush       (q_flush),
    .push_n      (q_push_n),
    .push_d0     (q_d0),
    .push_d1     (q_d1),
    .st          (bus_st)
  );
endmodule

// File: rtl/pfq_unit_chk.sv
module pfq_unit_chk
  import pfq_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          redir_valid,
  input logic          q_valid,
  input logic          q_ready,
  input logic          dreq_valid,
  input logic          dreq_done,
  input logic [AW-1:0] dreq_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic [CW-1:0] occ_count,
  input bus_st_t       bus_st
);
  // R1: occupancy never passes the depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ_count <= CW'(DEPTH));

  // R2: a fresh prefetch only starts with two free entries
  a_r2_fetch_room: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && !mem_we && bus_st == BUS_FETCH) |-> $past(occ_count) <= CW'(DEPTH - 2));

  // R4: an untaken head byte stays available
  a_r4_hold_head: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_ready && !redir_valid) |=> q_valid);

  // R5: an idle bus goes to the waiting data request
  a_r5_data_first: assert property (@(posedge clk) disable iff (rst)
    (bus_st == BUS_IDLE && dreq_valid && !dreq_done) |=> (mem_req && bus_st == BUS_DATA && mem_addr == $past(dreq_addr)));

  // R6: completion pulse follows the ready edge of a data transfer
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (bus_st == BUS_DATA && mem_req && mem_ready) |=> dreq_done);

  // R7: redirect empties the queue
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !q_valid);

  // R8: a fetch ending during a redirect adds nothing
  a_r8_drop_inflight: assert property (@(posedge clk) disable iff (rst)
    (bus_st == BUS_FETCH && mem_req && mem_ready && redir_valid) |=> occ_count == '0);

  // R9: request held steady until ready
  a_r9_req_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind pfq_unit pfq_unit_chk #(.AW(AW), .DEPTH(QDEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .redir_valid (redir_valid),
  .q_valid     (q_valid),
  .q_ready     (q_ready),
  .dreq_valid  (dreq_valid),
  .dreq_done   (dreq_done),
  .dreq_addr   (dreq_addr),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_ready   (mem_ready),
  .occ_count   (occ_count),
  .bus_st      (bus_st)
);

// File: tb/pfq_unit_test.sv
`timescale 1ns/1ps
module pfq_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redir_valid = 1'b0;
  logic [19:0] redir_addr = '0;
  logic        q_valid;
  logic [7:0]  q_byte;
  logic        q_ready = 1'b0;
  logic        dreq_valid = 1'b0;
  logic        dreq_write = 1'b0;
  logic [19:0] dreq_addr = '0;
  logic [15:0] dreq_wdata = '0;
  logic        dreq_done;
  logic [15:0] dreq_rdata;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int lat = 0;
  int wcnt = 0;

  logic [19:0] log_addr [256];
  logic        log_we   [256];
  logic [15:0] log_wd   [256];
  int n_tx = 0;

  always #4 clk = ~clk;

  pfq_unit uut (.*);

  function automatic logic [7:0] byte_at(input logic [19:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [15:0] word_at(input logic [19:0] a);
    logic [19:0] b;
    b = {a[19:1], 1'b0};
    return {byte_at(b + 20'd1), byte_at(b)};
  endfunction

  // memory model: answers after lat wait cycles, ready for one cycle
  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      wcnt      <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
      wcnt      <= 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= word_at(mem_addr);
      end else begin
        wcnt <= wcnt + 1;
      end
    end
    if (!rst && mem_req && mem_ready && n_tx < 256) begin
      log_addr[n_tx] <= mem_addr;
      log_we[n_tx]   <= mem_we;
      log_wd[n_tx]   <= mem_wdata;
      n_tx           <= n_tx + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mem_req);
  endtask

  task automatic redirect_now(input logic [19:0] a);
    redir_valid = 1'b1;
    redir_addr  = a;
    @(negedge clk);
    redir_valid = 1'b0;
    check(!q_valid, "R7 queue empty after redirect", 32'(q_valid), 32'd0);
  endtask

  task automatic redirect(input logic [19:0] a);
    wait_idle();
    redirect_now(a);
  endtask

  task automatic pop_bytes(input logic [19:0] a, input int n, input int gap, input logic [7:0] first);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!q_valid);
      check(q_byte == byte_at(a + 20'(i)), "R4 R3 byte order", 32'(q_byte), 32'(byte_at(a + 20'(i))));
      if (i == 0) check(q_byte == first, "R3 first byte", 32'(q_byte), 32'(first));
      q_ready = 1'b1;
      @(posedge clk);
      #1 q_ready = 1'b0;
      repeat (gap) @(posedge clk);
    end
  endtask

  // back-to-back drain of a settled queue, then expect it empty
  task automatic drain_full(input logic [19:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(q_valid && q_byte == byte_at(a + 20'(i)), "R1 full queue content", 32'(q_byte), 32'(byte_at(a + 20'(i))));
      q_ready = 1'b1;
    end
    @(posedge clk);
    #1 q_ready = 1'b0;
    @(negedge clk);
    check(!q_valid, "R1 occupancy limit", 32'(q_valid), 32'd0);
  endtask

  task automatic data_access(input bit wr, input logic [19:0] a, input logic [15:0] wd);
    dreq_valid = 1'b1;
    dreq_write = wr;
    dreq_addr  = a;
    dreq_wdata = wd;
    do @(negedge clk); while (!dreq_done);
    dreq_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [19:0] addr;
    logic [7:0]  lat;
    logic [7:0]  n;
    logic [7:0]  gap;
    logic [7:0]  first;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{20'h00100, 8'd0, 8'd12, 8'd0, 8'hA5},
    '{20'h12345, 8'd3, 8'd9,  8'd2, 8'hE0},
    '{20'hFFFFE, 8'd1, 8'd6,  8'd1, 8'h5B},
    '{20'h00007, 8'd5, 8'd10, 8'd3, 8'hA2}
  };

  initial begin
    int n0;
    // R10 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!q_valid && !mem_req && !dreq_done, "R10 reset outputs", {29'd0, q_valid, mem_req, dreq_done}, 32'd0);
    rst = 1'b0;
    do @(negedge clk); while (!mem_req);
    check(mem_addr == 20'hFFFF0, "R10 first fetch address", 32'(mem_addr), 32'hFFFF0);
    pop_bytes(20'hFFFF0, 3, 0, 8'h55);

    // table of streaming scenarios
    foreach (VEC[k]) begin
      lat = int'(VEC[k].lat);
      redirect(VEC[k].addr);
      pop_bytes(VEC[k].addr, int'(VEC[k].n), int'(VEC[k].gap), VEC[k].first);
    end

    // R1 R2 R3 even start fills to six
    lat = 0;
    redirect(20'h00400);
    n0 = n_tx;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(!mem_req, "R2 no fetch without room", 32'(mem_req), 32'd0);
    check(n_tx == n0 + 3, "R2 fetch count even", 32'(n_tx - n0), 32'd3);
    check(log_addr[n0 + 2] == 20'h00404, "R3 even step", 32'(log_addr[n0 + 2]), 32'h00404);
    lat = 20;
    drain_full(20'h00400, 6);

    // odd start fills to five
    lat = 0;
    redirect(20'h00401);
    n0 = n_tx;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(n_tx == n0 + 3, "R2 fetch count odd", 32'(n_tx - n0), 32'd3);
    check(log_addr[n0] == 20'h00401 && log_addr[n0 + 1] == 20'h00402,
          "R3 odd realign", 32'(log_addr[n0 + 1]), 32'h00402);
    lat = 20;
    drain_full(20'h00401, 5);

    // R5 data request during a prefetch
    lat = 4;
    redirect(20'h00600);
    do @(negedge clk); while (!(mem_req && mem_addr == 20'h00600));
    n0 = n_tx;
    data_access(1'b0, 20'h0ABCC, 16'h0000);
    check(dreq_rdata == 16'h6869, "R6 read data", 32'(dreq_rdata), 32'h6869);
    @(negedge clk);
    check(!dreq_done, "R6 done is a pulse", 32'(dreq_done), 32'd0);
    check(log_addr[n0] == 20'h00600 && !log_we[n0], "R5 fetch not aborted", 32'(log_addr[n0]), 32'h00600);
    check(log_addr[n0 + 1] == 20'h0ABCC, "R5 data before next fetch", 32'(log_addr[n0 + 1]), 32'h0ABCC);
    pop_bytes(20'h00600, 4, 0, 8'hA5);

    // R6 write
    lat = 2;
    wait_idle();
    data_access(1'b1, 20'h0100A, 16'hBEEF);
    check(log_we[n_tx - 1] && log_addr[n_tx - 1] == 20'h0100A && log_wd[n_tx - 1] == 16'hBEEF,
          "R6 write transfer", 32'(log_wd[n_tx - 1]), 32'hBEEF);

    // R8 redirect while a fetch is outstanding
    lat = 6;
    redirect(20'h00800);
    do @(negedge clk); while (!(mem_req && mem_addr == 20'h00800));
    n0 = n_tx;
    redirect_now(20'h00903);
    pop_bytes(20'h00903, 4, 0, 8'hA6);
    check(log_addr[n0 + 1] == 20'h00903, "R8 refetch at target", 32'(log_addr[n0 + 1]), 32'h00903);

    // R10 reset mid-run with bytes queued
    lat = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!q_valid && !mem_req, "R10 reset clears queue", {30'd0, q_valid, mem_req}, 32'd0);
    rst = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule